// File: doc/BRIEF.md
# Windowed Instruction Fetch Buffer

This block sits between a small instruction memory and the instruction decoder. It does not fetch one word per request. It loads an aligned group of eight consecutive instruction words in one multi-cycle memory access and keeps them in a local window register. While the program counter stays inside that window, the decoder gets each instruction straight from the local copy, with no memory wait. The block owns the program counter. The decoder steps it forward with an advance strobe, or redirects it with a taken-branch strobe and a target address.

A reload starts whenever the program counter leaves the current window. This happens when a sequential step crosses the eighth slot, or when a branch target lies in a different window. A branch whose target falls inside the current window is served at once. A lookahead comparator examines the address after the current one and tells the core one step ahead whether the next sequential fetch will be served from the window (fast) or will need a reload (slow).

Memory holds 128 words behind an 8-bit address. The buffer replaces every word at address 128 or above with a fixed no-operation encoding.

Top module: `fetch_window_buf`

## Requirements
- R1: While reset is asserted and after it is released, the program counter is 0 and `ready_o` is low. A load of the window based at address 0 is in progress, and `ready_o` rises after exactly `LOAD_LAT` clock cycles.
- R2: During a window load, `mem_rd_o` is high and `mem_addr_o` equals the program counter with its low three bits cleared. The load lasts exactly `LOAD_LAT` cycles, and `ready_o` stays low for all of them.
- R3: While `ready_o` is low, `adv_i` and `br_take_i` are ignored, and the program counter does not change.
- R4: While `ready_o` is high, `instr_o` is the word for `pc_o`. Slot i of `mem_data_i` (bits `[i*IW +: IW]`) is the word for address base+i, and it is captured at the end of the load.
- R5: With `ready_o` high, a cycle with `adv_i` set moves the program counter to pc+1, wrapping from 255 to 0. If pc+1 lies in the same window, `ready_o` stays high. Otherwise a reload starts.
- R6: With `ready_o` high, a cycle with `br_take_i` set loads the program counter with `br_target_i`, and the branch wins over `adv_i`. If the target lies in the current window, no reload takes place and `ready_o` stays high. Otherwise a reload starts.
- R7: Words at addresses 128 to 255 are delivered as `NOP_WORD` (default 12'hF00), whatever `mem_data_i` holds. `instr_o` is also `NOP_WORD` whenever `ready_o` is low.
- R8: `next_fast_o` is high only when `ready_o` is high and pc+1 lies in the current window. It is low at the last slot of a window, including pc 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Step to the next sequential instruction |
| br_take_i | input | 1 | Taken branch; load the target into the program counter |
| br_target_i | input | 8 | Branch target address |
| mem_data_i | input | 96 | Eight instruction words of the addressed window |
| mem_rd_o | output | 1 | Window load in progress |
| mem_addr_o | output | 8 | Base address of the window being loaded |
| instr_o | output | 12 | Instruction at the current program counter |
| pc_o | output | 8 | Current program counter |
| ready_o | output | 1 | Window valid; `instr_o` is usable |
| next_fast_o | output | 1 | Next sequential fetch is a window hit |

## Verification
The hardest case to reach is a redirect that arrives while a load is still running, because the port conditions that would act on it exist only for the `LOAD_LAT` cycles of the load. The bench triggers a reload with an out-of-window branch. It then holds both the advance and the branch strobes high, with a foreign target, until `ready_o` returns, and checks that the program counter and the loaded window are unchanged. The wrap at the top of the address space is reached by branching to address 255 and then stepping once.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
  typedef enum logic {
    ST_LOAD  = 1'b0,
    ST_READY = 1'b1
  } fstate_t;
endpackage

// File: rtl/fwb_ctrl.sv
module fwb_ctrl
  import fwb_pkg::*;
#(
  parameter int AW       = 8,
  parameter int OFS      = 3,
  parameter int LOAD_LAT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_i,
  input  logic            br_take_i,
  input  logic [AW-1:0]   br_target_i,
  output logic [AW-1:0]   pc_o,
  output logic [AW-OFS-1:0] base_o,
  output logic            loading_o,
  output logic            capture_o
);
  localparam int CW = (LOAD_LAT > 1) ? $clog2(LOAD_LAT) : 1;
  localparam logic [CW-1:0] CNT_INIT = CW'(LOAD_LAT - 1);

  fstate_t             st_q, st_d;
  logic [AW-1:0]       pc_q, pc_d;
  logic [AW-OFS-1:0]   base_q, base_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic [AW-1:0]       seq_pc;

  assign seq_pc = pc_q + AW'(1);

  always_comb begin
    st_d      = st_q;
    pc_d      = pc_q;
    base_d    = base_q;
    cnt_d     = cnt_q;
    capture_o = 1'b0;
    unique case (st_q)
      ST_LOAD: begin
        if (cnt_q == '0) begin
          st_d      = ST_READY;
          capture_o = 1'b1;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      ST_READY: begin
        if (br_take_i) begin
          pc_d = br_target_i;
          if (br_target_i[AW-1:OFS] != base_q) begin
            st_d   = ST_LOAD;
            base_d = br_target_i[AW-1:OFS];
            cnt_d  = CNT_INIT;
          end
        end else if (adv_i) begin
          pc_d = seq_pc;
          if (seq_pc[AW-1:OFS] != base_q) begin
            st_d   = ST_LOAD;
            base_d = seq_pc[AW-1:OFS];
            cnt_d  = CNT_INIT;
          end
        end
      end
      default: st_d = ST_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_LOAD;
      pc_q   <= '0;
      base_q <= '0;
      cnt_q  <= CNT_INIT;
    end else begin
      st_q   <= st_d;
      pc_q   <= pc_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  assign pc_o      = pc_q;
  assign base_o    = base_q;
  assign loading_o = (st_q == ST_LOAD);
endmodule

// File: rtl/fwb_window.sv
module fwb_window #(
  parameter int          AW        = 8,
  parameter int          IW        = 12,
  parameter int          WIN       = 8,
  parameter int          MEM_WORDS = 128,
  parameter logic [IW-1:0] NOP_WORD = 12'hF00
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   capture_i,
  input  logic [AW-$clog2(WIN)-1:0] base_i,
  input  logic [WIN*IW-1:0]      mem_data_i,
  input  logic [$clog2(WIN)-1:0] sel_i,
  output logic [IW-1:0]          word_o
);
  localparam int OFS = $clog2(WIN);

  logic [IW-1:0] slot_q [WIN];
  logic [IW-1:0] slot_d [WIN];

  for (genvar i = 0; i < WIN; i++) begin : g_slot
    logic [AW-1:0] slot_addr;
    assign slot_addr = {base_i, OFS'(i)};

    always_comb begin
      if (32'(slot_addr) >= MEM_WORDS) slot_d[i] = NOP_WORD;
      else                             slot_d[i] = mem_data_i[i*IW +: IW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         slot_q[i] <= NOP_WORD;
      else if (capture_i) slot_q[i] <= slot_d[i];
    end
  end

  assign word_o = slot_q[sel_i];
endmodule

// File: rtl/fwb_lookahead.sv
module fwb_lookahead #(
  parameter int AW  = 8,
  parameter int OFS = 3
) (
  input  logic              ready_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [AW-OFS-1:0] base_i,
  output logic              next_fast_o
);
  logic [AW-1:0] peek;
  assign peek        = pc_i + AW'(1);
  assign next_fast_o = ready_i && (peek[AW-1:OFS] == base_i);
endmodule

// File: rtl/fetch_window_buf.sv
module fetch_window_buf #(
  parameter int          AW        = 8,
  parameter int          IW        = 12,
  parameter int          WIN       = 8,
  parameter int          MEM_WORDS = 128,
  parameter int          LOAD_LAT  = 4,
  parameter logic [IW-1:0] NOP_WORD = 12'hF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              br_take_i,
  input  logic [AW-1:0]     br_target_i,
  input  logic [WIN*IW-1:0] mem_data_i,
  output logic              mem_rd_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [IW-1:0]     instr_o,
  output logic [AW-1:0]     pc_o,
  output logic              ready_o,
  output logic              next_fast_o
);
  localparam int OFS = $clog2(WIN);

  logic [AW-OFS-1:0] base;
  logic              loading;
  logic              capture;
  logic [IW-1:0]     win_word;

  fwb_ctrl #(.AW(AW), .OFS(OFS), .LOAD_LAT(LOAD_LAT)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .adv_i       (adv_i),
    .br_take_i   (br_take_i),
    .br_target_i (br_target_i),
    .pc_o        (pc_o),
    .base_o      (base),
    .loading_o   (loading),
    .capture_o   (capture)
  );

  fwb_window #(.AW(AW), .IW(IW), .WIN(WIN), .MEM_WORDS(MEM_WORDS),
               .NOP_WORD(NOP_WORD)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_i  (capture),
    .base_i     (base),
    .mem_data_i (mem_data_i),
    .sel_i      (pc_o[OFS-1:0]),
    .word_o     (win_word)
  );

  fwb_lookahead #(.AW(AW), .OFS(OFS)) u_look (
    .ready_i     (ready_o),
    .pc_i        (pc_o),
    .base_i      (base),
    .next_fast_o (next_fast_o)
  );

  assign ready_o    = !loading;
  assign mem_rd_o   = loading;
  assign mem_addr_o = {base, OFS'(0)};
  assign instr_o    = ready_o ? win_word : NOP_WORD;
endmodule

// File: rtl/fwb_checker.sv
module fwb_checker #(
  parameter int          AW       = 8,
  parameter int          IW       = 12,
  parameter int          WIN      = 8,
  parameter logic [IW-1:0] NOP_WORD = 12'hF00
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adv_i,
  input logic          br_take_i,
  input logic [AW-1:0] br_target_i,
  input logic          mem_rd_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [IW-1:0] instr_o,
  input logic [AW-1:0] pc_o,
  input logic          ready_o,
  input logic          next_fast_o
);
  localparam int OFS = $clog2(WIN);

  a_r2_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> (mem_addr_o[OFS-1:0] == '0 && mem_addr_o[AW-1:OFS] == pc_o[AW-1:OFS]));

  a_r3_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> $stable(pc_o));

  a_r5_fast_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && adv_i && !br_take_i && next_fast_o) |=> ready_o);

  a_r8_slow_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && adv_i && !br_take_i && !next_fast_o) |=> !ready_o);

  a_r6_near_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && br_take_i && br_target_i[AW-1:OFS] == pc_o[AW-1:OFS])
      |=> (ready_o && pc_o == $past(br_target_i)));

  a_r7_high_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && pc_o[AW-1]) |-> instr_o == NOP_WORD);
endmodule

bind fetch_window_buf fwb_checker #(.AW(AW), .IW(IW), .WIN(WIN), .NOP_WORD(NOP_WORD)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .adv_i       (adv_i),
  .br_take_i   (br_take_i),
  .br_target_i (br_target_i),
  .mem_rd_o    (mem_rd_o),
  .mem_addr_o  (mem_addr_o),
  .instr_o     (instr_o),
  .pc_o        (pc_o),
  .ready_o     (ready_o),
  .next_fast_o (next_fast_o)
);

// File: tb/sim_fetch_window_buf.sv
`timescale 1ns/1ps
module sim_fetch_window_buf;
  localparam int AW = 8, IW = 12, WIN = 8, LAT = 4;
  localparam logic [IW-1:0] NOP = 12'hF00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adv = 1'b0, br = 1'b0;
  logic [AW-1:0] tgt = '0;
  logic [WIN*IW-1:0] mdata;
  logic mrd, rdy, fast;
  logic [AW-1:0] maddr, pc;
  logic [IW-1:0] instr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  function automatic logic [IW-1:0] fw(logic [AW-1:0] a);
    return IW'({4'h0, a} * 12'd7 + 12'h101);
  endfunction

  always_comb
    for (int i = 0; i < WIN; i++) mdata[i*IW +: IW] = fw(maddr + AW'(i));

  fetch_window_buf u0 (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .br_take_i(br), .br_target_i(tgt),
    .mem_data_i(mdata), .mem_rd_o(mrd), .mem_addr_o(maddr), .instr_o(instr),
    .pc_o(pc), .ready_o(rdy), .next_fast_o(fast));

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic a, input logic b, input logic [AW-1:0] t);
    adv = a; br = b; tgt = t;
    @(posedge clk);
    @(negedge clk);
    adv = 0; br = 0;
  endtask

  task automatic wait_ready(input logic [AW-1:0] exp_base, input string tag);
    int n = 0;
    check(int'(mrd), 1, {tag, " R2 mem_rd during load"});
    check(int'(maddr), int'(exp_base), {tag, " R2 mem_addr"});
    while (!rdy && n < 50) begin
      check(int'(instr), int'(NOP), {tag, " R7 nop while loading"});
      n++;
      @(negedge clk);
    end
    check(n, LAT, {tag, " R2 load length"});
  endtask

  task automatic t_reset();
    #1;
    check(int'(rdy), 0, "R1 ready in reset");
    check(int'(pc), 0, "R1 pc in reset");
    check(int'(fast), 0, "R8 fast in reset");
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    wait_ready(8'd0, "R1 reset");
  endtask

  task automatic t_sequential();
    for (int k = 0; k < WIN; k++) begin
      check(int'(pc), k, "R5 pc step");
      check(int'(instr), int'(fw(AW'(k))), "R4 window word");
      check(int'(fast), (k != WIN - 1) ? 1 : 0, "R8 lookahead");
      if (k < WIN - 1) begin
        pulse(1, 0, '0);
        check(int'(rdy), 1, "R5 in-window step keeps ready");
      end
    end
    pulse(1, 0, '0);
    check(int'(rdy), 0, "R5 crossing starts reload");
    wait_ready(8'd8, "R5 cross");
    check(int'(pc), 8, "R5 pc after cross");
    check(int'(instr), int'(fw(8'd8)), "R4 first word new window");
  endtask

  task automatic t_branch_near();
    pulse(0, 1, 8'd13);
    check(int'(rdy), 1, "R6 near branch no reload");
    check(int'(pc), 13, "R6 near branch pc");
    check(int'(instr), int'(fw(8'd13)), "R6 near branch word");
    pulse(1, 1, 8'd10);
    check(int'(pc), 10, "R6 branch beats advance");
    check(int'(rdy), 1, "R6 priority no reload");
  endtask

  task automatic t_ignore_in_load();
    adv = 0; br = 1; tgt = 8'd200;
    @(posedge clk);
    @(negedge clk);
    adv = 1; br = 1; tgt = 8'd3;
    wait_ready(8'd200, "R3 far branch");
    adv = 0; br = 0;
    check(int'(pc), 200, "R3 strobes ignored while loading");
    check(int'(instr), int'(NOP), "R7 high address nop");
    check(int'(fast), 1, "R8 fast mid window");
  endtask

  task automatic t_wrap();
    pulse(0, 1, 8'd255);
    wait_ready(8'd248, "R6 far branch");
    check(int'(instr), int'(NOP), "R7 nop at 255");
    check(int'(fast), 0, "R8 slow at 255");
    pulse(1, 0, '0);
    wait_ready(8'd0, "R5 wrap");
    check(int'(pc), 0, "R5 wrap pc");
    check(int'(instr), int'(fw(8'd0)), "R4 word after wrap");
  endtask

  initial begin
    t_reset();
    t_sequential();
    t_branch_near();
    t_ignore_in_load();
    t_wrap();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule